// File: doc/BRIEF.md
# Paired Store Issue Unit

This unit accepts one 32-bit store-pair instruction word. It reads the two data registers and the base register through a combinational register-read port, and it also takes the stack-pointer value. From these it decodes the data size and the indexing mode, and it scales the signed seven-bit immediate. It then issues the memory traffic on a valid/ready write port. A configuration input chooses between two kinds of traffic. In wide mode, both words go out in one write of twice the data size, and the word order depends on the endianness input. In split mode, two writes go out back to back at consecutive addresses.

When the mode updates the base register, the unit issues a single-cycle writeback request after the last write has been accepted. The unit reports three conditions through single-cycle flags: malformed encodings, a misaligned stack pointer, and overlap between a data register and the base register. A policy input chooses how an overlap is resolved. The unit takes a new instruction only while it is idle.

Top module: `stp_issue_unit`

## Requirements
- R1: An instruction is accepted when it is presented on `ins_valid` while `ins_ready` is high. It is well formed only when all of the following hold:
  - bits 29:27 are 101, bit 26 is 0 and bit 22 is 0;
  - bits 31:30 are 00 (32-bit data) or 10 (64-bit data);
  - bits 25:23 are 001, 010 or 011.
  Otherwise `flag_undef` pulses in the cycle after acceptance, and no write and no writeback follow.
- R2: The other fields are: bits 21:15 the signed immediate, bits 14:10 the second data register, bits 9:5 the base register, bits 4:0 the first data register. The byte offset is the immediate sign-extended and shifted left by 2 for 32-bit data or by 3 for 64-bit data. The mode codes are 001 post-index, 011 pre-index and 010 offset-only. The write address is the base plus the offset for 011 and 010, and the unmodified base for 001.
- R3: In split mode (`cfg_wide_access`=0), the first write carries data1 at the computed address. The second carries data2 at that address plus 4 (32-bit data) or plus 8 (64-bit data). `mw_bytes` is 4 or 8, and the data sits in the low bits of `mw_data`.
- R4: In wide mode, one write of 8 or 16 bytes is issued. With `cfg_big_endian`=0, data1 occupies the low half of the combined value and data2 the high half. With `cfg_big_endian`=1 the halves are swapped.
- R5: Modes 001 and 011 raise `wb_valid` for exactly one cycle, the cycle after the last write is accepted. `wb_idx` is the base register number (31 means the stack pointer), and `wb_value` is the base plus the offset. Mode 010 produces no writeback.
- R6: A base register number of 31 selects `sp_value` as the base. If the low four bits of `sp_value` are not all zero, `flag_sp_fault` pulses and no write and no writeback follow.
- R7: An overlap exists when the mode writes back, the base register number is not 31, and either data register number equals it. For a well-formed encoding, `flag_overlap` pulses. `cfg_overlap_policy` then decides the outcome:
  - 0: store the register values as read, before writeback;
  - 1: replace the overlapping register's data with the fill parameter (default A5A55A5AC3C33C3C);
  - 2: treat the instruction as malformed;
  - 3: do nothing.
- R8: While `mw_valid` is high and `mw_ready` is low, the write address, data and size hold steady.
- R9: After reset, and whenever `ins_ready` is high, `mw_valid` and `wb_valid` are low.
- R10: For 32-bit data, only the low 32 bits of each data register are stored. All bits of `mw_data` above the stored size are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ins_valid | input | 1 | Instruction offered |
| ins_ready | output | 1 | Unit idle, instruction taken |
| ins_word | input | 32 | Instruction word |
| cfg_wide_access | input | 1 | 1: single double-width write |
| cfg_big_endian | input | 1 | Word order for the wide write |
| cfg_overlap_policy | input | 2 | Overlap resolution |
| sp_value | input | 64 | Stack pointer value |
| rf_idx_t1 | output | 5 | Read index, first data register |
| rf_idx_t2 | output | 5 | Read index, second data register |
| rf_idx_base | output | 5 | Read index, base register |
| rf_val_t1 | input | 64 | First data register value |
| rf_val_t2 | input | 64 | Second data register value |
| rf_val_base | input | 64 | Base register value |
| mw_valid | output | 1 | Write request valid |
| mw_ready | input | 1 | Write request accepted |
| mw_addr | output | 64 | Write byte address |
| mw_data | output | 128 | Write data, low-aligned |
| mw_bytes | output | 5 | Write size in bytes |
| wb_valid | output | 1 | Base writeback request |
| wb_idx | output | 5 | Writeback register number |
| wb_value | output | 64 | Writeback value |
| flag_undef | output | 1 | Malformed encoding pulse |
| flag_sp_fault | output | 1 | Misaligned stack pointer pulse |
| flag_overlap | output | 1 | Base/data overlap pulse |

## Verification
The bench attacks each corner with a targeted case:
- Immediate extremes (+63 and -64): a missing sign extension or a wrong scale gives wrong addresses.
- Post-index against pre-index: applying the offset before the access, or writing back early, moves the stored address or the writeback cycle.
- Both word orders in wide mode for each data size: a swapped concatenation puts data1 in the wrong half.
- All four overlap policies, a misaligned stack pointer and several malformed encodings: a unit that fails to suppress traffic emits writes or a writeback that the model does not expect.
- Random back-pressure on the write port: a unit that drops or changes a stalled write is caught.

// File: rtl/stp_issue_unit.sv
module stp_issue_unit #(
  parameter int          XLEN          = 64,
  parameter int          SP_ALIGN_BITS = 4,
  parameter logic [63:0] UNKNOWN_FILL  = 64'hA5A5_5A5A_C3C3_3C3C
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ins_valid,
  output logic                  ins_ready,
  input  logic [31:0]           ins_word,
  input  logic                  cfg_wide_access,
  input  logic                  cfg_big_endian,
  input  logic [1:0]            cfg_overlap_policy,
  input  logic [XLEN-1:0]       sp_value,
  output logic [4:0]            rf_idx_t1,
  output logic [4:0]            rf_idx_t2,
  output logic [4:0]            rf_idx_base,
  input  logic [XLEN-1:0]       rf_val_t1,
  input  logic [XLEN-1:0]       rf_val_t2,
  input  logic [XLEN-1:0]       rf_val_base,
  output logic                  mw_valid,
  input  logic                  mw_ready,
  output logic [XLEN-1:0]       mw_addr,
  output logic [2*XLEN-1:0]     mw_data,
  output logic [$clog2(XLEN/4):0] mw_bytes,
  output logic                  wb_valid,
  output logic [4:0]            wb_idx,
  output logic [XLEN-1:0]       wb_value,
  output logic                  flag_undef,
  output logic                  flag_sp_fault,
  output logic                  flag_overlap
);
  localparam int HALF   = XLEN / 2;
  localparam int BW     = $clog2(XLEN/4) + 1;
  localparam int NARROW = XLEN / 16;
  localparam int FULL   = XLEN / 8;

  typedef enum logic [1:0] {S_IDLE, S_WR1, S_WR2, S_WB} state_t;
  state_t st;

  logic [1:0] opc;
  logic [2:0] mode;
  logic [6:0] imm7;
  logic [4:0] rt, rt2, rn;
  assign opc  = ins_word[31:30];
  assign mode = ins_word[25:23];
  assign imm7 = ins_word[21:15];
  assign rt2  = ins_word[14:10];
  assign rn   = ins_word[9:5];
  assign rt   = ins_word[4:0];

  assign rf_idx_t1   = rt;
  assign rf_idx_t2   = rt2;
  assign rf_idx_base = rn;

  logic enc_ok, is64, wback, post, ovl, fill, undef_d, fault_d, nop_d, go;
  assign enc_ok = ins_word[29:27] == 3'b101 && !ins_word[26] && !ins_word[22]
                  && !opc[0] && (mode == 3'b001 || mode == 3'b010 || mode == 3'b011);
  assign is64   = opc[1];
  assign wback  = mode != 3'b010;
  assign post   = mode == 3'b001;
  assign ovl    = enc_ok && wback && rn != 5'd31 && (rt == rn || rt2 == rn);
  assign fill   = ovl && cfg_overlap_policy == 2'd1;
  assign undef_d = !enc_ok || (ovl && cfg_overlap_policy == 2'd2);
  assign fault_d = !undef_d && rn == 5'd31 && |sp_value[SP_ALIGN_BITS-1:0];
  assign nop_d   = ovl && cfg_overlap_policy == 2'd3;
  assign go      = !undef_d && !fault_d && !nop_d;

  logic [XLEN-1:0] base, offset, sum, raw1, raw2, d1, d2;
  assign base   = (rn == 5'd31) ? sp_value : rf_val_base;
  assign offset = {{(XLEN-7){imm7[6]}}, imm7} << (is64 ? 3 : 2);
  assign sum    = base + offset;
  assign raw1   = (fill && rt  == rn) ? UNKNOWN_FILL[XLEN-1:0] : rf_val_t1;
  assign raw2   = (fill && rt2 == rn) ? UNKNOWN_FILL[XLEN-1:0] : rf_val_t2;
  assign d1     = is64 ? raw1 : {{HALF{1'b0}}, raw1[HALF-1:0]};
  assign d2     = is64 ? raw2 : {{HALF{1'b0}}, raw2[HALF-1:0]};

  logic [2*XLEN-1:0] joined;
  always_comb begin
    if (is64)
      joined = cfg_big_endian ? {d1, d2} : {d2, d1};
    else
      joined = cfg_big_endian ? {{XLEN{1'b0}}, d1[HALF-1:0], d2[HALF-1:0]}
                              : {{XLEN{1'b0}}, d2[HALF-1:0], d1[HALF-1:0]};
  end

  logic [XLEN-1:0]   r_addr, r_d1, r_d2, r_wbval;
  logic [2*XLEN-1:0] r_joined;
  logic              r_is64, r_wide, r_wback;
  logic [4:0]        r_rn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st            <= S_IDLE;
      flag_undef    <= 1'b0;
      flag_sp_fault <= 1'b0;
      flag_overlap  <= 1'b0;
      r_addr        <= '0;
      r_d1          <= '0;
      r_d2          <= '0;
      r_wbval       <= '0;
      r_joined      <= '0;
      r_is64        <= 1'b0;
      r_wide        <= 1'b0;
      r_wback       <= 1'b0;
      r_rn          <= '0;
    end else begin
      flag_undef    <= 1'b0;
      flag_sp_fault <= 1'b0;
      flag_overlap  <= 1'b0;
      case (st)
        S_IDLE: if (ins_valid) begin
          flag_undef    <= undef_d;
          flag_sp_fault <= fault_d;
          flag_overlap  <= ovl;
          if (go) begin
            st       <= S_WR1;
            r_addr   <= post ? base : sum;
            r_wbval  <= sum;
            r_d1     <= d1;
            r_d2     <= d2;
            r_joined <= joined;
            r_is64   <= is64;
            r_wide   <= cfg_wide_access;
            r_wback  <= wback;
            r_rn     <= rn;
          end
        end
        S_WR1: if (mw_ready) st <= r_wide ? (r_wback ? S_WB : S_IDLE) : S_WR2;
        S_WR2: if (mw_ready) st <= r_wback ? S_WB : S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign ins_ready = st == S_IDLE;
  assign mw_valid  = st == S_WR1 || st == S_WR2;
  assign mw_addr   = (st == S_WR2) ? r_addr + XLEN'(r_is64 ? FULL : NARROW) : r_addr;
  assign mw_data   = (st == S_WR2) ? {{XLEN{1'b0}}, r_d2}
                   : r_wide        ? r_joined
                                   : {{XLEN{1'b0}}, r_d1};
  assign mw_bytes  = r_wide ? BW'(r_is64 ? 2*FULL : 2*NARROW)
                            : BW'(r_is64 ? FULL : NARROW);
  assign wb_valid  = st == S_WB;
  assign wb_idx    = r_rn;
  assign wb_value  = r_wbval;
endmodule

// File: rtl/stp_issue_unit_chk.sv
module stp_issue_unit_chk #(
  parameter int XLEN = 64
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     ins_ready,
  input logic                     mw_valid,
  input logic                     mw_ready,
  input logic [XLEN-1:0]          mw_addr,
  input logic [2*XLEN-1:0]        mw_data,
  input logic [$clog2(XLEN/4):0]  mw_bytes,
  input logic                     wb_valid,
  input logic                     flag_undef,
  input logic                     flag_sp_fault
);
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mw_valid && !mw_ready |=> mw_valid && $stable(mw_addr) && $stable(mw_data) && $stable(mw_bytes));

  assert_wb_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |=> !wb_valid);

  assert_wb_after_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> $past(mw_valid && mw_ready));

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ins_ready |-> !mw_valid && !wb_valid);

  assert_flag_exclusive_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({flag_undef, flag_sp_fault}));

  assert_fault_no_traffic_R6: assert property (@(posedge clk) disable iff (!rst_n)
    flag_sp_fault || flag_undef |-> ins_ready);
endmodule

bind stp_issue_unit stp_issue_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .ins_ready(ins_ready), .mw_valid(mw_valid),
  .mw_ready(mw_ready), .mw_addr(mw_addr), .mw_data(mw_data), .mw_bytes(mw_bytes),
  .wb_valid(wb_valid), .flag_undef(flag_undef), .flag_sp_fault(flag_sp_fault)
);

// File: tb/stp_issue_unit_tb.sv
module stp_issue_unit_tb;
  localparam logic [63:0] FILL = 64'hA5A5_5A5A_C3C3_3C3C;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, ins_valid = 1'b0, cfg_wide = 1'b0, cfg_be = 1'b0, mw_ready = 1'b0;
  logic [31:0] ins_word = '0;
  logic [1:0] cfg_pol = '0;
  logic [63:0] sp_value = '0;
  logic [4:0] rf_idx_t1, rf_idx_t2, rf_idx_base, mw_bytes, wb_idx;
  logic [63:0] rf_val_t1, rf_val_t2, rf_val_base, mw_addr, wb_value;
  logic [127:0] mw_data;
  logic ins_ready, mw_valid, wb_valid, flag_undef, flag_sp_fault, flag_overlap;
  logic [63:0] regs [32];

  assign rf_val_t1   = regs[rf_idx_t1];
  assign rf_val_t2   = regs[rf_idx_t2];
  assign rf_val_base = regs[rf_idx_base];

  stp_issue_unit u_dut (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_ready(ins_ready),
    .ins_word(ins_word), .cfg_wide_access(cfg_wide), .cfg_big_endian(cfg_be),
    .cfg_overlap_policy(cfg_pol), .sp_value(sp_value),
    .rf_idx_t1(rf_idx_t1), .rf_idx_t2(rf_idx_t2), .rf_idx_base(rf_idx_base),
    .rf_val_t1(rf_val_t1), .rf_val_t2(rf_val_t2), .rf_val_base(rf_val_base),
    .mw_valid(mw_valid), .mw_ready(mw_ready), .mw_addr(mw_addr), .mw_data(mw_data),
    .mw_bytes(mw_bytes), .wb_valid(wb_valid), .wb_idx(wb_idx), .wb_value(wb_value),
    .flag_undef(flag_undef), .flag_sp_fault(flag_sp_fault), .flag_overlap(flag_overlap)
  );

  int total = 0, fails = 0;

  task automatic chk(input bit ok, input string tag, input string act, input string exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%s expected=%s", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  function automatic logic [31:0] enc(input logic [1:0] opc, input logic [2:0] mode,
                                      input logic [6:0] imm, input logic [4:0] rt2,
                                      input logic [4:0] rn, input logic [4:0] rt);
    return {opc, 3'b101, 1'b0, mode, 1'b0, imm, rt2, rn, rt};
  endfunction

  task automatic issue(input string name, input logic [31:0] w, input bit wide, input bit be,
                       input logic [1:0] pol, input logic [63:0] sp);
    logic [1:0] opc = w[31:30];
    logic [2:0] mode = w[25:23];
    logic [4:0] rt = w[4:0], rn = w[9:5], rt2 = w[14:10];
    bit ok, is64, wbk, ovl, undef, fault, nop, go;
    logic [63:0] base, off, m, d1, d2, a;
    logic [63:0] e_addr [2];
    logic [127:0] e_data [2];
    int e_bytes [2];
    int n_exp, got, wb_seen, sh;
    bit prev_stall;
    logic [63:0] p_addr;
    logic [127:0] p_data;

    ok = w[29:27] == 3'b101 && !w[26] && !w[22] && (opc == 2'b00 || opc == 2'b10)
         && (mode == 3'd1 || mode == 3'd2 || mode == 3'd3);
    is64 = opc == 2'b10;
    wbk = mode != 3'd2;
    ovl = ok && wbk && rn != 5'd31 && (rt == rn || rt2 == rn);
    undef = !ok || (ovl && pol == 2'd2);
    fault = !undef && rn == 5'd31 && sp[3:0] != 4'd0;
    nop = ovl && pol == 2'd3;
    go = !undef && !fault && !nop;
    base = (rn == 5'd31) ? sp : regs[rn];
    sh = is64 ? 3 : 2;
    off = 64'($signed(w[21:15])) * (64'd1 << sh);
    a = (mode == 3'd1) ? base : base + off;
    m = is64 ? '1 : 64'hFFFF_FFFF;
    d1 = ((pol == 2'd1 && ovl && rt == rn) ? FILL : regs[rt]) & m;
    d2 = ((pol == 2'd1 && ovl && rt2 == rn) ? FILL : regs[rt2]) & m;
    n_exp = 0;
    if (go) begin
      if (wide) begin
        e_addr[0] = a;
        e_data[0] = be ? ((128'(d1) << (is64 ? 64 : 32)) | 128'(d2))
                       : ((128'(d2) << (is64 ? 64 : 32)) | 128'(d1));
        e_bytes[0] = is64 ? 16 : 8;
        n_exp = 1;
      end else begin
        e_addr[0] = a;               e_data[0] = 128'(d1); e_bytes[0] = is64 ? 8 : 4;
        e_addr[1] = a + (is64 ? 8 : 4); e_data[1] = 128'(d2); e_bytes[1] = is64 ? 8 : 4;
        n_exp = 2;
      end
    end

    @(negedge clk);
    ins_word = w; cfg_wide = wide; cfg_be = be; cfg_pol = pol; sp_value = sp; ins_valid = 1'b1;
    #0.1;
    chk(ins_ready, {name, " R9 ready"}, $sformatf("%0b", ins_ready), "1");
    @(negedge clk);
    ins_valid = 1'b0;
    chk(flag_undef == undef, {name, " R1 undef"}, $sformatf("%0b", flag_undef), $sformatf("%0b", undef));
    chk(flag_sp_fault == fault, {name, " R6 fault"}, $sformatf("%0b", flag_sp_fault), $sformatf("%0b", fault));
    chk(flag_overlap == ovl, {name, " R7 overlap"}, $sformatf("%0b", flag_overlap), $sformatf("%0b", ovl));

    got = 0; wb_seen = 0; prev_stall = 0;
    for (int c = 0; c < 60; c++) begin
      mw_ready = ($urandom % 3) != 0;
      #0.1;
      if (prev_stall)
        chk(mw_valid && mw_addr == p_addr && mw_data == p_data, {name, " R8 hold"},
            $sformatf("%h/%h", mw_addr, mw_data), $sformatf("%h/%h", p_addr, p_data));
      prev_stall = mw_valid && !mw_ready;
      p_addr = mw_addr; p_data = mw_data;
      if (mw_valid && mw_ready) begin
        if (got >= n_exp)
          chk(1'b0, {name, " R1 R6 R7 unexpected write"}, $sformatf("%h", mw_addr), "none");
        else begin
          chk(mw_addr == e_addr[got], {name, " R2 R3 addr"}, $sformatf("%h", mw_addr), $sformatf("%h", e_addr[got]));
          chk(mw_data == e_data[got], {name, " R4 R10 data"}, $sformatf("%h", mw_data), $sformatf("%h", e_data[got]));
          chk(int'(mw_bytes) == e_bytes[got], {name, " R3 size"}, $sformatf("%0d", mw_bytes), $sformatf("%0d", e_bytes[got]));
        end
        got++;
      end
      if (wb_valid) begin
        wb_seen++;
        chk(go && wbk && got == n_exp && wb_idx == rn && wb_value == base + off, {name, " R5 writeback"},
            $sformatf("%0d:%h", wb_idx, wb_value), $sformatf("%0d:%h", rn, base + off));
      end
      if (ins_ready && c >= 3) break;
      @(negedge clk);
    end
    chk(got == n_exp, {name, " R3 R4 write count"}, $sformatf("%0d", got), $sformatf("%0d", n_exp));
    chk(wb_seen == ((go && wbk) ? 1 : 0), {name, " R5 writeback count"},
        $sformatf("%0d", wb_seen), $sformatf("%0d", (go && wbk) ? 1 : 0));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    summary();
  end

  initial begin
    for (int i = 0; i < 32; i++)
      regs[i] = 64'h0123_4567_89AB_CDEF ^ (64'(i) * 64'h1111_2222_0101_0303);
    regs[31] = '0;
    regs[5] = 64'h0000_0000_0010_0000;
    repeat (3) @(negedge clk);
    chk(!mw_valid && !wb_valid, "R9 reset quiet", $sformatf("%0b%0b", mw_valid, wb_valid), "00");
    rst_n = 1'b1;
    @(negedge clk);
    chk(ins_ready && !mw_valid && !wb_valid, "R9 idle after reset",
        $sformatf("%0b%0b%0b", ins_ready, mw_valid, wb_valid), "100");

    issue("post32 split LE",  enc(2'b00, 3'd1, 7'd5,   5'd2, 5'd5, 5'd1), 0, 0, 2'd0, 64'h0);
    issue("pre64 wide LE",    enc(2'b10, 3'd3, 7'h7E,  5'd4, 5'd5, 5'd3), 1, 0, 2'd0, 64'h0);
    issue("pre64 wide BE",    enc(2'b10, 3'd3, 7'd3,   5'd4, 5'd5, 5'd3), 1, 1, 2'd0, 64'h0);
    issue("off32 wide BE",    enc(2'b00, 3'd2, 7'd1,   5'd7, 5'd5, 5'd6), 1, 1, 2'd0, 64'h0);
    issue("off32 wide LE",    enc(2'b00, 3'd2, 7'd63,  5'd7, 5'd5, 5'd6), 1, 0, 2'd0, 64'h0);
    issue("off64 split min",  enc(2'b10, 3'd2, 7'h40,  5'd9, 5'd31, 5'd8), 0, 0, 2'd0, 64'h0000_8000_0000_1000);
    issue("post64 sp wb",     enc(2'b10, 3'd1, 7'h7F,  5'd9, 5'd31, 5'd8), 0, 0, 2'd0, 64'h0000_0000_0000_2000);
    issue("sp misaligned",    enc(2'b10, 3'd3, 7'd2,   5'd9, 5'd31, 5'd8), 0, 0, 2'd0, 64'h0000_0000_0000_2008);
    issue("undef opc01",      enc(2'b01, 3'd3, 7'd2,   5'd9, 5'd5, 5'd8), 0, 0, 2'd0, 64'h0);
    issue("undef mode000",    enc(2'b00, 3'd0, 7'd2,   5'd9, 5'd5, 5'd8), 0, 0, 2'd0, 64'h0);
    issue("undef load bit",   enc(2'b00, 3'd2, 7'd2,   5'd9, 5'd5, 5'd8) | 32'h0040_0000, 0, 0, 2'd0, 64'h0);
    issue("overlap pol0",     enc(2'b10, 3'd3, 7'd1,   5'd5, 5'd5, 5'd8), 0, 0, 2'd0, 64'h0);
    issue("overlap pol1",     enc(2'b10, 3'd1, 7'd1,   5'd9, 5'd5, 5'd5), 0, 0, 2'd1, 64'h0);
    issue("overlap pol1 w32", enc(2'b00, 3'd3, 7'd2,   5'd5, 5'd5, 5'd8), 1, 0, 2'd1, 64'h0);
    issue("overlap pol2",     enc(2'b10, 3'd3, 7'd1,   5'd5, 5'd5, 5'd8), 0, 0, 2'd2, 64'h0);
    issue("overlap pol3",     enc(2'b10, 3'd1, 7'd1,   5'd9, 5'd5, 5'd5), 0, 0, 2'd3, 64'h0);
    issue("no overlap off",   enc(2'b10, 3'd2, 7'd1,   5'd5, 5'd5, 5'd5), 1, 1, 2'd2, 64'h0);
    summary();
  end
endmodule